// File: doc/BRIEF.md
# SMBus Clock-Control Register Slave

This block is the serial control port of a clock generator. It watches a two-wire SMBus (SCL and SDA), answers at one fixed 7-bit address, and holds a small file of control bytes. It drives the rest of the chip with the current contents of those bytes. The bus pins are sampled on the system clock. SDA is driven back as an open-drain pull-down request, so the pad only ever pulls the line low.

Four transfers are accepted. Bit 7 of the command byte chooses between them. When bit 7 is 1, the transfer is an indexed single-byte access at the offset in bits 6:0. When bit 7 is 0, it is a block transfer. A block always starts at register index 4, because lower indices belong to other devices on the same address. A block write carries a count byte before its data. A block read returns a count byte before its data. A few bytes are not plain storage. Index 4 carries frequency-select bits guarded by a software-enable bit. Index 5 reflects the strap pins. Index 8 is a fixed signature.

Top module: `smb_clkreg_slave`

## Requirements
- R1: After reset SDA is released and the register view is: index 4 shows strap values with stored bits 0, index 6 = 0x0B, index 7 = 0xFF, index 9 = 0xB0, index 10 = 0xFF, index 11 = 0x00.
- R2: START (SDA falling while SCL is high) restarts address reception at any point, including as a repeated start. STOP (SDA rising while SCL is high) ends any transfer and releases SDA. A transfer cut short by STOP in the middle of a byte writes nothing.
- R3: The address byte 0xD2 (7-bit 0x69, bit 0 = read flag) is acknowledged. Any other address is not acknowledged, and the slave then ignores the bus until the next START or STOP.
- R4: Byte write: a command byte with bit 7 = 1 selects the offset in bits 6:0. The next data byte is written there. The slave acknowledges every byte.
- R5: Byte read: command write, repeated start, address with read flag. The slave returns the byte at the offset, most significant bit first.
- R6: Block write: command 0x00, then a count byte that is acknowledged but not stored, then data to indices 4, 5, 6 and upward. STOP after any whole byte leaves the later registers untouched.
- R7: Block read: the slave first returns a count equal to NUM_REGS, then indices 4 upward. It continues while the master acknowledges and stops sending after a not-acknowledge.
- R8: Index 4 layout: bits 7,6,5,4 are FS3,FS2,FS1,FS0, bit 2 is FS4, bit 3 is the software-select enable, and bits 1:0 are plain storage. The FS bits are written only when the stored enable is 1. While the enable is 0, the FS bits read back the strap inputs.
- R9: Index 5 reads {2'b00, mult strap, fs strap[4:0]} and index 8 reads 0x80. Writes to either have no effect.
- R10: Indices below 4, and indices at 4+NUM_REGS or above, are acknowledged. Writes to them are ignored and reads of them return 0x00.
- R11: The slave changes its SDA drive only one cycle after a detected SCL falling edge, except for the release on START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SMBus clock line |
| sda_i | input | 1 | SMBus data line as seen at the pad |
| sda_low_o | output | 1 | 1 = pull SDA low (open-drain enable) |
| fs_strap_i | input | 5 | Frequency-select strap values FS4..FS0 |
| mult_strap_i | input | 1 | Current-multiplier strap value |
| regs_o | output | NUM_REGS*8 | Read view of indices 4.. , byte k at bits 8k+7:8k |

## Verification
The bench uses the default parameters: eight registers (indices 4 to 11), a two-stage synchronizer and address 0x69. With these values, index 12 is the first index past the top of the file, so the upper out-of-range edge can be reached by a byte read. The expected block-read count of 8 is short enough to check every returned byte. With the bit-banged master at 16 system clocks per SCL phase, the synchronizer delay lands inside each SCL phase. This lets the bench watch the open-drain output for any change while SCL is high.

// File: rtl/smb_clkreg_pkg.sv
package smb_clkreg_pkg;

  localparam int FIRST_IDX = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK, ST_SKIP
  } st_e;

  typedef enum logic [1:0] {PH_ADDR, PH_CMD, PH_DATA} ph_e;

  typedef enum logic [1:0] {RK_RW, RK_FSEL, RK_STRAP, RK_SIG} reg_kind_e;

  function automatic reg_kind_e reg_kind(int idx);
    case (idx)
      4:       return RK_FSEL;
      5:       return RK_STRAP;
      8:       return RK_SIG;
      default: return RK_RW;
    endcase
  endfunction

  function automatic logic [7:0] reg_default(int idx);
    case (idx)
      6:       return 8'h0B;
      7:       return 8'hFF;
      8:       return 8'h80;
      9:       return 8'hB0;
      10:      return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q, scl_s, sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s      = scl_ff[SYNC_STAGES-1];
  assign sda_s      = sda_ff[SYNC_STAGES-1];
  assign sda_s_o    = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/smb_clkreg_file.sv
module smb_clkreg_file
  import smb_clkreg_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [6:0]            wr_idx_i,
  input  logic [7:0]            wr_data_i,
  input  logic [6:0]            rd_idx_i,
  output logic [7:0]            rd_data_o,
  input  logic [4:0]            fs_strap_i,
  input  logic                  mult_strap_i,
  output logic [NUM_REGS*8-1:0] regs_o
);
  logic [7:0] view [NUM_REGS];

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    localparam int        IDX  = FIRST_IDX + k;
    localparam reg_kind_e KIND = reg_kind(IDX);
    logic hit;
    assign hit = wr_en_i && (int'(wr_idx_i) == IDX);

    if (KIND == RK_RW) begin : g_rw
      logic [7:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  q <= reg_default(IDX);
        else if (hit) q <= wr_data_i;
      end
      assign view[k] = q;
    end else if (KIND == RK_FSEL) begin : g_fsel
      logic [7:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= reg_default(IDX);
        else if (hit) begin
          if (q[3]) q <= wr_data_i;
          else      q <= {q[7:4], wr_data_i[3], q[2], wr_data_i[1:0]};
        end
      end
      // enable low: FS fields mirror straps
      assign view[k] = q[3] ? q
                     : {fs_strap_i[3:0], q[3], fs_strap_i[4], q[1:0]};
    end else if (KIND == RK_STRAP) begin : g_strap
      assign view[k] = {2'b00, mult_strap_i, fs_strap_i};
    end else begin : g_sig
      assign view[k] = reg_default(IDX);
    end

    assign regs_o[k*8 +: 8] = view[k];
  end

  always_comb begin
    rd_data_o = 8'h00;
    for (int k = 0; k < NUM_REGS; k++)
      if (int'(rd_idx_i) == FIRST_IDX + k) rd_data_o = view[k];
  end
endmodule

// File: rtl/smb_clkreg_slave.sv
module smb_clkreg_slave
  import smb_clkreg_pkg::*;
#(
  parameter int         NUM_REGS    = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR    = 7'h69
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_low_o,
  input  logic [4:0]            fs_strap_i,
  input  logic                  mult_strap_i,
  output logic [NUM_REGS*8-1:0] regs_o
);
  localparam logic [6:0] BLK_BASE = 7'(FIRST_IDX);
  localparam logic [7:0] BLK_CNT  = 8'(NUM_REGS);

  logic sda_s, scl_rise_ev, scl_fall_ev, start_ev, stop_ev;

  smb_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_s_o   (sda_s),
    .scl_rise_o(scl_rise_ev),
    .scl_fall_o(scl_fall_ev),
    .start_o   (start_ev),
    .stop_o    (stop_ev)
  );

  st_e        st;
  ph_e        ph;
  logic [3:0] cnt;
  logic [7:0] sh, tx;
  logic [6:0] ptr;
  logic       sda_low, rw, blk, cnt_pending, send_cnt, macked;
  logic       wr_en, in_skip;
  logic [7:0] rd_data, tx_next;

  assign wr_en = (st == ST_RX) && scl_fall_ev && (cnt == 4'd8) && (ph == PH_DATA)
               && !cnt_pending && !start_ev && !stop_ev;
  assign tx_next = send_cnt ? BLK_CNT : rd_data;
  assign in_skip = (st == ST_SKIP);

  smb_clkreg_file #(.NUM_REGS(NUM_REGS)) u_file (
    .clk_i, .rst_ni,
    .wr_en_i  (wr_en),
    .wr_idx_i (ptr),
    .wr_data_i(sh),
    .rd_idx_i (ptr),
    .rd_data_o(rd_data),
    .fs_strap_i, .mult_strap_i,
    .regs_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= ST_IDLE; ph <= PH_ADDR; cnt <= '0; sh <= '0; tx <= '0; ptr <= BLK_BASE;
      sda_low <= 1'b0; rw <= 1'b0; blk <= 1'b0; cnt_pending <= 1'b0;
      send_cnt <= 1'b0; macked <= 1'b0;
    end else if (start_ev) begin
      st <= ST_RX; ph <= PH_ADDR; cnt <= '0; sda_low <= 1'b0;
    end else if (stop_ev) begin
      st <= ST_IDLE; sda_low <= 1'b0;
    end else begin
      unique case (st)
        ST_RX: begin
          if (scl_rise_ev && cnt != 4'd8) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end
          if (scl_fall_ev && cnt == 4'd8) begin
            cnt <= '0;
            unique case (ph)
              PH_ADDR: begin
                if (sh[7:1] == DEV_ADDR) begin
                  rw <= sh[0]; send_cnt <= sh[0] & blk;
                  sda_low <= 1'b1; st <= ST_RX_ACK;
                end else st <= ST_SKIP;
              end
              PH_CMD: begin
                blk <= ~sh[7]; cnt_pending <= ~sh[7];
                ptr <= sh[7] ? sh[6:0] : BLK_BASE;
                sda_low <= 1'b1; st <= ST_RX_ACK;
              end
              default: begin
                if (cnt_pending) cnt_pending <= 1'b0;
                else             ptr <= ptr + 7'd1;
                sda_low <= 1'b1; st <= ST_RX_ACK;
              end
            endcase
          end
        end
        ST_RX_ACK: if (scl_fall_ev) begin
          if (ph == PH_ADDR && rw) begin
            tx <= tx_next; sda_low <= ~tx_next[7]; cnt <= '0; st <= ST_TX;
            if (send_cnt) send_cnt <= 1'b0;
            else          ptr <= ptr + 7'd1;
          end else begin
            sda_low <= 1'b0; st <= ST_RX;
            ph <= (ph == PH_ADDR) ? PH_CMD : PH_DATA;
          end
        end
        ST_TX: if (scl_fall_ev) begin
          if (cnt == 4'd7) begin
            sda_low <= 1'b0; cnt <= '0; st <= ST_TX_ACK;
          end else begin
            tx <= {tx[6:0], 1'b0}; sda_low <= ~tx[6]; cnt <= cnt + 4'd1;
          end
        end
        ST_TX_ACK: begin
          if (scl_rise_ev) macked <= ~sda_s;
          if (scl_fall_ev) begin
            if (macked) begin
              tx <= tx_next; sda_low <= ~tx_next[7]; st <= ST_TX;
              if (send_cnt) send_cnt <= 1'b0;
              else          ptr <= ptr + 7'd1;
            end else st <= ST_SKIP;
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_low_o = sda_low;
endmodule

// File: rtl/smb_clkreg_slave_chk.sv
module smb_clkreg_slave_chk #(
  parameter int NUM_REGS = 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  scl_fall_ev,
  input logic                  start_ev,
  input logic                  stop_ev,
  input logic                  in_skip,
  input logic                  sda_low_o,
  input logic [NUM_REGS*8-1:0] regs_o
);
  a_r11_drive_after_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_low_o) |-> $past(scl_fall_ev));

  a_r2_stop_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_ev |=> !sda_low_o);

  a_r2_start_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_ev |=> !sda_low_o);

  a_r3_silent_when_unaddressed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_skip |-> !sda_low_o);

  if (NUM_REGS >= 3) begin : g_rw_chk
    a_r4_write_at_ack_point: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(regs_o[23:16]) |-> $past(scl_fall_ev));
  end
endmodule

bind smb_clkreg_slave smb_clkreg_slave_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_fall_ev(scl_fall_ev),
  .start_ev   (start_ev),
  .stop_ev    (stop_ev),
  .in_skip    (in_skip),
  .sda_low_o  (sda_low_o),
  .regs_o     (regs_o)
);

// File: tb/smb_clkreg_slave_bench.sv
module smb_clkreg_slave_bench;
  localparam int NREG = 8;
  localparam int HT   = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_low;
  logic [NREG*8-1:0] regs;
  logic sda_line;
  int n_chk = 0, n_bad = 0, r11_viol = 0, scl_hi = 0;
  logic prev_low = 1'b0;
  bit done = 0;

  always #4 clk = ~clk;
  assign sda_line = sda_m & ~sda_low;

  smb_clkreg_slave #(.NUM_REGS(NREG)) u_smb_clkreg_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_low_o(sda_low), .fs_strap_i(5'b10110), .mult_strap_i(1'b1),
    .regs_o(regs)
  );

  // R11 monitor: no drive change while SCL has been high for a while
  always @(negedge clk) begin
    if (scl_m) scl_hi++; else scl_hi = 0;
    if (rst_n && scl_hi > 4 && sda_low != prev_low) r11_viol++;
    prev_low = sda_low;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] view(input int idx);
    return regs[(idx-4)*8 +: 8];
  endfunction

  task automatic hold(); repeat (HT) @(negedge clk); endtask

  task automatic bit_out(input logic b);
    sda_m = b; hold(); scl_m = 1'b1; hold(); scl_m = 1'b0;
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; hold(); scl_m = 1'b1;
    repeat (HT/2) @(negedge clk);
    b = sda_line;
    repeat (HT/2) @(negedge clk);
    scl_m = 1'b0;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hold(); scl_m = 1'b1; hold(); sda_m = 1'b0; hold(); scl_m = 1'b0; hold();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold(); scl_m = 1'b1; hold(); sda_m = 1'b1; hold(); hold();
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(b);
    ack = ~b;
  endtask

  task automatic rbyte(input logic nack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin bit_in(b); d[i] = b; end
    bit_out(nack);
  endtask

  task automatic byte_write(input string req, input logic [7:0] cmd, input logic [7:0] d);
    logic a0, a1, a2;
    bus_start(); wbyte(8'hD2, a0); wbyte(cmd, a1); wbyte(d, a2); bus_stop();
    chk(req, {5'b0, a0, a1, a2}, 8'h07);
  endtask

  task automatic byte_read(input string req, input logic [7:0] cmd, output logic [7:0] d);
    logic a0, a1, a2;
    bus_start(); wbyte(8'hD2, a0); wbyte(cmd, a1);
    bus_start(); wbyte(8'hD3, a2); rbyte(1'b1, d); bus_stop();
    chk(req, {5'b0, a0, a1, a2}, 8'h07);
  endtask

  task automatic t_reset();
    chk("R1 sda", {7'b0, sda_low}, 8'h00);
    chk("R1/R8 idx4", view(4), 8'h64);
    chk("R9 idx5", view(5), 8'h36);
    chk("R1 idx6", view(6), 8'h0B);
    chk("R1 idx7", view(7), 8'hFF);
    chk("R9 idx8", view(8), 8'h80);
    chk("R1 idx9", view(9), 8'hB0);
    chk("R1 idx10", view(10), 8'hFF);
    chk("R1 idx11", view(11), 8'h00);
  endtask

  task automatic t_byte_rw();
    logic [7:0] d;
    byte_write("R4 acks", 8'h87, 8'h5A);
    chk("R4 idx7", view(7), 8'h5A);
    byte_read("R5 acks", 8'h87, d);
    chk("R5 read idx7", d, 8'h5A);
    byte_write("R9 acks", 8'h85, 8'hFF);
    byte_read("R9 acks", 8'h85, d);
    chk("R9 idx5 read", d, 8'h36);
    byte_write("R9 acks", 8'h88, 8'h12);
    byte_read("R9 acks", 8'h88, d);
    chk("R9 idx8 read", d, 8'h80);
  endtask

  task automatic t_wrong_addr();
    logic a0, a1, a2;
    bus_start(); wbyte(8'hD4, a0); wbyte(8'h86, a1); wbyte(8'h00, a2); bus_stop();
    chk("R3 no ack", {5'b0, a0, a1, a2}, 8'h00);
    chk("R3 idx6 kept", view(6), 8'h0B);
  endtask

  task automatic t_fsel();
    byte_write("R8 acks", 8'h84, 8'hF4);
    chk("R8 locked", view(4), 8'h64);
    byte_write("R8 acks", 8'h84, 8'h08);
    chk("R8 enable", view(4), 8'h08);
    byte_write("R8 acks", 8'h84, 8'hFC);
    chk("R8 sw fs", view(4), 8'hFC);
    byte_write("R8 acks", 8'h84, 8'h01);
    chk("R8 back to strap", view(4), 8'h65);
  endtask

  task automatic t_block_write();
    logic a [6];
    bus_start(); wbyte(8'hD2, a[0]); wbyte(8'h00, a[1]); wbyte(8'h03, a[2]);
    wbyte(8'h08, a[3]); wbyte(8'hAA, a[4]); wbyte(8'h3C, a[5]); bus_stop();
    chk("R6 acks", {2'b0, a[0], a[1], a[2], a[3], a[4], a[5]}, 8'h3F);
    chk("R6 idx4", view(4), 8'h08);
    chk("R9 idx5 block", view(5), 8'h36);
    chk("R6 idx6", view(6), 8'h3C);
    chk("R6 early stop idx7", view(7), 8'h5A);
  endtask

  task automatic t_block_read();
    logic a0, a1, a2;
    logic [7:0] d;
    logic [7:0] exp [NREG] = '{8'h08, 8'h36, 8'h3C, 8'h5A, 8'h80, 8'hB0, 8'hFF, 8'h00};
    bus_start(); wbyte(8'hD2, a0); wbyte(8'h00, a1);
    bus_start(); wbyte(8'hD3, a2);
    chk("R7 acks", {5'b0, a0, a1, a2}, 8'h07);
    rbyte(1'b0, d);
    chk("R7 count", d, 8'(NREG));
    for (int i = 0; i < NREG; i++) begin
      rbyte(i == NREG-1, d);
      chk("R7 data", d, exp[i]);
    end
    bus_stop();
    chk("R7 released", {7'b0, sda_low}, 8'h00);
  endtask

  task automatic t_out_of_range();
    logic [7:0] d;
    byte_write("R10 acks low", 8'h82, 8'h77);
    byte_read("R10 acks low", 8'h82, d);
    chk("R10 low read", d, 8'h00);
    byte_write("R10 acks high", 8'h8C, 8'h77);
    byte_read("R10 acks high", 8'h8C, d);
    chk("R10 high read", d, 8'h00);
    chk("R10 idx6 kept", view(6), 8'h3C);
  endtask

  task automatic t_restart();
    logic a [6];
    logic [7:0] d;
    bus_start(); wbyte(8'hD2, a[0]); wbyte(8'h86, a[1]);
    bus_start(); wbyte(8'hD2, a[2]); wbyte(8'h87, a[3]); wbyte(8'h11, a[4]); bus_stop();
    chk("R2 restart idx7", view(7), 8'h11);
    chk("R2 restart idx6", view(6), 8'h3C);
    bus_start(); bit_out(1'b1); bit_out(1'b1); bit_out(1'b0); bus_stop();
    chk("R2 mid-byte stop", {7'b0, sda_low}, 8'h00);
    byte_read("R2 acks", 8'h86, d);
    chk("R2 after abort", d, 8'h3C);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_byte_rw();
    t_wrong_addr();
    t_fsel();
    t_block_write();
    t_block_read();
    t_out_of_range();
    t_restart();
    n_chk++;
    if (r11_viol != 0) begin
      n_bad++;
      $display("FAIL R11: got %0d changes with SCL high expected 0", r11_viol);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule